// File: doc/BRIEF.md
# Conflict-Allocated Instruction Cache

This block sits between the instruction sequencer and a single-port program-memory bus that serves both instruction fetches and data reads. When the sequencer fetches in a cycle where no data access wants the bus, the fetch goes straight to the bus and the cache is neither read for the result nor written. When a fetch and a data access want the bus in the same cycle, the cache is looked up. On a hit the instruction comes from the cache while the bus serves the data access, so both finish in that cycle. On a miss the data access takes the bus, a stall is raised for one cycle, and in the next cycle the bus fetches the held instruction address. That word goes to the sequencer and is written into the cache.

Only words whose fetch collided with a data access are allocated. A tight loop that reads operands over the program bus therefore stalls once per colliding instruction on its first pass and runs at full speed on later passes. The store is direct-mapped. Each entry has a valid bit and a tag, and it is indexed by the low bits of the fetch address. A flush input invalidates every entry at once.

Top module: `conflict_icache`

## Requirements
- R1: After reset every entry is invalid, stall is low and no instruction is valid while no fetch is requested. The first colliding fetch of any address misses.
- R2: A fetch with no data request and no pending refill drives bus_addr = fetch_addr and data_gnt = 0. It returns instr_valid = 1 and instr_word = bus_rdata in the same cycle, with stall = 0 and instr_hit = 0.
- R3: A fetch with no data request writes nothing into the cache. A later colliding fetch of the same address still misses.
- R4: A colliding fetch (fetch_req and data_req together, no refill pending) that misses grants the bus to data (data_gnt = 1, bus_addr = data_addr). It raises stall = 1 and gives instr_valid = 0.
- R5: In the cycle after a stall, the bus fetches the address captured at the stall. The block gives instr_valid = 1 and instr_word = bus_rdata, with stall = 0 and data_gnt = 0, and writes that word into the cache.
- R6: A colliding fetch that hits gives instr_valid = 1, instr_hit = 1 and stall = 0, with the cached word on instr_word, while data_gnt = 1 and bus_addr = data_addr.
- R7: The cache is direct-mapped on fetch_addr[4:0]. An address with the same index but different upper bits misses and replaces the entry.
- R8: flush invalidates every entry at the next clock edge. When flush coincides with a refill write, the entry is still left invalid.
- R9: A data request with no fetch and no pending refill gets data_gnt = 1, bus_addr = data_addr and instr_valid = 0.
- R10: A loop whose instructions all collide with data reads stalls once per instruction on the first pass and never on later passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Invalidate all cache entries |
| fetch_req | input | 1 | Sequencer requests an instruction |
| fetch_addr | input | 16 | Instruction address |
| data_req | input | 1 | Data access wants the program bus |
| data_addr | input | 16 | Data access address |
| bus_rdata | input | 48 | Word returned by the bus for bus_addr, same cycle |
| bus_addr | output | 16 | Address placed on the program bus |
| data_gnt | output | 1 | Bus is serving the data access this cycle |
| instr_valid | output | 1 | instr_word holds the fetched instruction |
| instr_word | output | 48 | Delivered instruction |
| instr_hit | output | 1 | Instruction came from the cache |
| stall | output | 1 | Fetch delayed one cycle by a collision miss |

## Verification
The assertions assume the sequencer holds fetch_req and fetch_addr through a stall. They also assume a data request that is not granted during a refill cycle is simply retried, and that bus_rdata is a pure function of bus_addr. The stimulus issues the stalled fetch again with the same address in the refill cycle. It drives a fixed address-to-word mapping for the bus, so every delivered word can be predicted. The reference model treats a data request raised in a refill cycle as ungranted and expects nothing more from it.

// File: rtl/ci_pkg.sv
// Package: shared types for the conflict-allocated instruction cache.
// Assumes: nothing beyond IEEE 1800-2017.
package ci_pkg;
    // Which requester owns the program bus in a cycle.
    typedef enum logic [1:0] {
        OWN_NONE   = 2'd0,
        OWN_FETCH  = 2'd1,
        OWN_DATA   = 2'd2,
        OWN_REFILL = 2'd3
    } owner_e;
endpackage

// File: rtl/ci_tag_store.sv
// Module: valid bits and tags, one register set per entry.
// Reads are combinational. One write per cycle. Flush has priority over
// a write to the valid bit.
// Assumes: widx is in range (ENTRIES is a power of two).
module ci_tag_store #(
    parameter int ENTRIES = 32,
    parameter int TAGW    = 11,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [TAGW-1:0] wtag,
    input  logic [IDXW-1:0] ridx,
    output logic            rvalid,
    output logic [TAGW-1:0] rtag
);
    logic [ENTRIES-1:0] valid_q;
    logic [TAGW-1:0]    tag_q [ENTRIES];

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_entry
            // Valid bit: cleared by reset or flush, set on a write to this entry.
            always_ff @(posedge clk) begin
                if (!rst_n || flush)
                    valid_q[e] <= 1'b0;
                else if (we && widx == IDXW'(e))
                    valid_q[e] <= 1'b1;
            end

            // Tag: captured on a write to this entry.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    tag_q[e] <= '0;
                else if (we && widx == IDXW'(e))
                    tag_q[e] <= wtag;
            end
        end
    endgenerate

    // Read port: entry selected by index.
    always_comb begin
        rvalid = valid_q[ridx];
        rtag   = tag_q[ridx];
    end
endmodule

// File: rtl/ci_data_store.sv
// Module: instruction word array for the cache.
// Has a combinational read and one write per cycle.
// Assumes: a stale word behind an invalid entry is never delivered.
module ci_data_store #(
    parameter int ENTRIES = 32,
    parameter int IW      = 48,
    localparam int IDXW   = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IDXW-1:0] widx,
    input  logic [IW-1:0]   wdata,
    input  logic [IDXW-1:0] ridx,
    output logic [IW-1:0]   rdata
);
    logic [IW-1:0] word_q [ENTRIES];

    genvar e;
    generate
        for (e = 0; e < ENTRIES; e++) begin : g_word
            // Word register: loaded when this entry is written.
            always_ff @(posedge clk) begin
                if (we && widx == IDXW'(e))
                    word_q[e] <= wdata;
            end
        end
    endgenerate

    // Read port.
    assign rdata = word_q[ridx];
endmodule

// File: rtl/ci_ctrl.sv
// Module: bus arbitration and refill sequencing.
// Decides which requester owns the bus, raises the stall on a colliding
// miss, and holds the stalled address for the refill cycle.
// Assumes: the sequencer holds its fetch during a stall.
module ci_ctrl #(
    parameter int AW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fetch_req,
    input  logic [AW-1:0]   fetch_addr,
    input  logic            data_req,
    input  logic            lookup_hit,
    output ci_pkg::owner_e  owner,
    output logic            stall,
    output logic            conflict_hit,
    output logic            refill_we,
    output logic [AW-1:0]   refill_addr
);
    import ci_pkg::*;

    logic pend_q;
    logic conflict;

    assign conflict = fetch_req && data_req && !pend_q;

    // Stall and hit decision for the current cycle.
    always_comb begin
        stall        = conflict && !lookup_hit;
        conflict_hit = conflict && lookup_hit;
        refill_we    = pend_q;
    end

    // Bus owner: a refill goes first, then data, then a plain fetch.
    always_comb begin
        if (pend_q)
            owner = OWN_REFILL;
        else if (data_req)
            owner = OWN_DATA;
        else if (fetch_req)
            owner = OWN_FETCH;
        else
            owner = OWN_NONE;
    end

    // Refill pending flag: set by a stall, lasts exactly one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else
            pend_q <= stall;
    end

    // Held fetch address for the refill.
    always_ff @(posedge clk) begin
        if (!rst_n)
            refill_addr <= '0;
        else if (stall)
            refill_addr <= fetch_addr;
    end
endmodule

// File: rtl/conflict_icache.sv
// Module: top of the conflict-allocated instruction cache.
// Looks up the cache only when a fetch collides with a program-bus data
// access. It serves hits from the cache and refills misses one cycle later.
// Assumes: bus_rdata is valid in the same cycle for the current bus_addr.
module conflict_icache #(
    parameter int AW      = 16,
    parameter int IW      = 48,
    parameter int ENTRIES = 32,
    localparam int IDXW   = $clog2(ENTRIES),
    localparam int TAGW   = AW - IDXW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          fetch_req,
    input  logic [AW-1:0] fetch_addr,
    input  logic          data_req,
    input  logic [AW-1:0] data_addr,
    input  logic [IW-1:0] bus_rdata,
    output logic [AW-1:0] bus_addr,
    output logic          data_gnt,
    output logic          instr_valid,
    output logic [IW-1:0] instr_word,
    output logic          instr_hit,
    output logic          stall
);
    import ci_pkg::*;

    owner_e          owner;
    logic            rvalid;
    logic [TAGW-1:0] rtag;
    logic [IW-1:0]   cache_word;
    logic            lookup_hit;
    logic            conflict_hit;
    logic            refill_we;
    logic [AW-1:0]   refill_addr;

    ci_tag_store #(.ENTRIES(ENTRIES), .TAGW(TAGW)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .we     (refill_we),
        .widx   (refill_addr[IDXW-1:0]),
        .wtag   (refill_addr[AW-1:IDXW]),
        .ridx   (fetch_addr[IDXW-1:0]),
        .rvalid (rvalid),
        .rtag   (rtag)
    );

    ci_data_store #(.ENTRIES(ENTRIES), .IW(IW)) u_words (
        .clk   (clk),
        .we    (refill_we),
        .widx  (refill_addr[IDXW-1:0]),
        .wdata (bus_rdata),
        .ridx  (fetch_addr[IDXW-1:0]),
        .rdata (cache_word)
    );

    // Tag compare for the fetch address.
    assign lookup_hit = rvalid && (rtag == fetch_addr[AW-1:IDXW]);

    ci_ctrl #(.AW(AW)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_req    (fetch_req),
        .fetch_addr   (fetch_addr),
        .data_req     (data_req),
        .lookup_hit   (lookup_hit),
        .owner        (owner),
        .stall        (stall),
        .conflict_hit (conflict_hit),
        .refill_we    (refill_we),
        .refill_addr  (refill_addr)
    );

    // Bus address mux by owner.
    always_comb begin
        case (owner)
            OWN_REFILL: bus_addr = refill_addr;
            OWN_DATA:   bus_addr = data_addr;
            default:    bus_addr = fetch_addr;
        endcase
    end

    // Instruction delivery: from the cache on a colliding hit, else from the bus.
    always_comb begin
        data_gnt    = (owner == OWN_DATA);
        instr_hit   = conflict_hit;
        instr_valid = (owner == OWN_REFILL) || (owner == OWN_FETCH) || conflict_hit;
        instr_word  = conflict_hit ? cache_word : bus_rdata;
    end
endmodule

// File: rtl/ci_checker.sv
// Module: temporal checks on the cache's ports, bound to the top.
// Assumes: the fetch is held through a stall.
module ci_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          fetch_req,
    input logic [AW-1:0] fetch_addr,
    input logic          data_req,
    input logic [AW-1:0] data_addr,
    input logic [AW-1:0] bus_addr,
    input logic          data_gnt,
    input logic          instr_valid,
    input logic          instr_hit,
    input logic          stall
);
    // R4: a stall needs both requesters, and data gets the bus.
    assert_stall_on_collision_R4: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (fetch_req && data_req && data_gnt && !instr_valid));

    // R5: a stall is always followed by a refill delivery with the bus kept from data.
    assert_refill_after_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (instr_valid && !stall && !data_gnt && !instr_hit));

    // R6: a hit never stalls and leaves the bus to data.
    assert_hit_serves_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        instr_hit |-> (!stall && data_gnt && instr_valid && bus_addr == data_addr));

    // R9: a data grant places the data address on the bus.
    assert_gnt_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_gnt |-> (bus_addr == data_addr));

    // R2: a lone fetch outside a refill goes straight to the bus without stalling.
    assert_plain_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !data_req && !$past(stall)) |->
            (instr_valid && !stall && !instr_hit && bus_addr == fetch_addr));

    // R8: after a flush, a collision cannot hit.
    assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && fetch_req && data_req && !$past(stall)) |-> !instr_hit);
endmodule

bind conflict_icache ci_checker #(.AW(AW)) u_chk (.*);

// File: tb/tb_conflict_icache.sv
// Bench: behavioural reference model compared with the cache every cycle.
module tb_conflict_icache;
    localparam int AW = 16;
    localparam int IW = 48;
    localparam int NE = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush = 1'b0;
    logic          fetch_req = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          data_req = 1'b0;
    logic [AW-1:0] data_addr = '0;
    logic [IW-1:0] bus_rdata;
    logic [AW-1:0] bus_addr;
    logic          data_gnt, instr_valid, instr_hit, stall;
    logic [IW-1:0] instr_word;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    function automatic logic [IW-1:0] memw(input logic [AW-1:0] a);
        return {a ^ 16'hA5A5, ~a, a};
    endfunction

    assign bus_rdata = memw(bus_addr);

    conflict_icache #(.AW(AW), .IW(IW), .ENTRIES(NE)) dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .data_req(data_req), .data_addr(data_addr),
        .bus_rdata(bus_rdata), .bus_addr(bus_addr), .data_gnt(data_gnt),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .instr_hit(instr_hit), .stall(stall)
    );

    // Reference model state
    bit            m_valid [NE];
    int            m_line  [NE];
    bit            m_pend = 0;
    logic [AW-1:0] m_paddr = '0;

    task automatic step(input bit f, input logic [AW-1:0] fa, input bit d,
                        input logic [AW-1:0] da, input bit fl, input string tag);
        logic [AW-1:0] e_bus; bit e_gnt, e_iv, e_hit, e_st;
        logic [IW-1:0] e_word; bit ok; int idx; bit alloc;
        @(negedge clk);
        fetch_req = f; fetch_addr = fa; data_req = d; data_addr = da; flush = fl;
        #1;
        e_bus = fa; e_gnt = 0; e_iv = 0; e_hit = 0; e_st = 0; e_word = '0; alloc = 0;
        idx = int'(fa) % NE;
        if (m_pend) begin
            e_bus = m_paddr; e_iv = 1; e_word = memw(m_paddr); alloc = 1;
        end else if (f && d) begin
            e_bus = da; e_gnt = 1;
            if (m_valid[idx] && m_line[idx] == int'(fa)) begin
                e_iv = 1; e_hit = 1; e_word = memw(fa);
            end else e_st = 1;
        end else if (f) begin
            e_iv = 1; e_word = memw(fa);
        end else if (d) begin
            e_bus = da; e_gnt = 1;
        end
        ok = (bus_addr == e_bus) && (data_gnt == e_gnt) && (instr_valid == e_iv) &&
             (instr_hit == e_hit) && (stall == e_st) && (!e_iv || instr_word == e_word);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: got bus=%h gnt=%b iv=%b hit=%b st=%b w=%h exp bus=%h gnt=%b iv=%b hit=%b st=%b w=%h",
                     tag, bus_addr, data_gnt, instr_valid, instr_hit, stall, instr_word,
                     e_bus, e_gnt, e_iv, e_hit, e_st, e_word);
        end
        @(posedge clk);
        if (alloc) begin
            m_valid[int'(m_paddr) % NE] = 1; m_line[int'(m_paddr) % NE] = int'(m_paddr);
        end
        if (fl) for (int i = 0; i < NE; i++) m_valid[i] = 0;
        m_pend = e_st;
        if (e_st) m_paddr = fa;
    endtask

    // Colliding fetch: issue again in the refill cycle if it stalled.
    task automatic cfetch(input logic [AW-1:0] fa, input logic [AW-1:0] da, input string tag);
        bit will_stall;
        will_stall = !(m_valid[int'(fa) % NE] && m_line[int'(fa) % NE] == int'(fa));
        step(1, fa, 1, da, 0, tag);
        if (will_stall) step(1, fa, 0, '0, 0, "R5");
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin m_valid[i] = 0; m_line[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: idle after reset
        step(0, 16'h0000, 0, 16'h0000, 0, "R1");
        // R2: plain fetches from the bus
        step(1, 16'h0040, 0, 16'h0000, 0, "R2");
        step(1, 16'h0041, 0, 16'h0000, 0, "R2");
        // R3 / R4: the earlier plain fetch did not allocate; collision misses
        step(1, 16'h0040, 1, 16'h9000, 0, "R3");
        // R5: refill cycle
        step(1, 16'h0040, 0, 16'h0000, 0, "R5");
        // R6: collision now hits
        step(1, 16'h0040, 1, 16'h9004, 0, "R6");
        // R9: lone data access
        step(0, 16'h0000, 1, 16'h9100, 0, "R9");
        // R7: alias on index 0 replaces, original then misses
        cfetch(16'h0060, 16'h9200, "R7");
        step(1, 16'h0060, 1, 16'h9204, 0, "R7");
        cfetch(16'h0040, 16'h9208, "R7");
        // R10: loop of 4 colliding instructions, 3 passes
        for (int p = 0; p < 3; p++)
            for (int k = 0; k < 4; k++)
                cfetch(16'h0100 + AW'(k), 16'hA000 + AW'(k), "R10");
        // R8: flush invalidates everything
        step(0, 16'h0000, 0, 16'h0000, 1, "R8");
        step(1, 16'h0101, 1, 16'hA010, 0, "R8");
        // R8: flush in the refill cycle wins over the write
        step(1, 16'h0101, 0, 16'h0000, 1, "R8");
        step(1, 16'h0101, 1, 16'hA020, 0, "R8");
        step(1, 16'h0101, 0, 16'h0000, 0, "R5");
        step(1, 16'h0101, 1, 16'hA024, 0, "R6");
        // R4: data request raised in refill cycle is not granted
        step(1, 16'h0222, 1, 16'hB000, 0, "R4");
        step(1, 16'h0222, 1, 16'hB000, 0, "R5");
        step(0, 16'h0000, 0, 16'h0000, 0, "R1");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule